// File: doc/BRIEF.md
# Four-Order Accumulator Processor Core

This block is an 18-bit, word-parallel, stored-program processor with the smallest useful order code. Each word read from memory as an instruction carries a 2-bit opcode in its top two bits and a 16-bit address in the rest. The four orders are: store the accumulator, add a memory word to the accumulator, jump if the accumulator is negative, and operate. Arithmetic is one's complement and works between the memory buffer and the accumulator. The operate order does not use its low bits as an address. Each of those bits instead enables one register transfer, and the enabled transfers take effect one after another in a fixed step order within the same instruction.

The core talks to one synchronous single-port word memory. A write takes effect at the clock edge. Read data comes back one clock after the address is presented. Because of that latency, each machine cycle takes two clocks and each instruction takes two machine cycles: a fetch and an execute.

Control is a five-state machine:
- `S_HALT`: idle.
- `S_FADR`: fetch, address phase. The PC drives the memory address.
- `S_FDAT`: fetch, data phase. The instruction is captured into MBR, IR and MAR, and the PC is incremented.
- `S_XADR`: execute, address phase. MAR drives the address, and a store writes here.
- `S_XDAT`: execute, data phase. The order completes.

The transitions are:
- **start**: `S_HALT`→`S_FADR`, when run is high and no halt is pending.
- **step**: `S_FADR`→`S_FDAT`→`S_XADR`→`S_XDAT`.
- **continue**: `S_XDAT`→`S_FADR`.
- **stop**: `S_XDAT`→`S_HALT`, when the operate halt bit is set or run is low.

A halt taken by the operate order stays pending until run is seen low. Registers are observable on output ports.

Top module: `acc18_core`

## Requirements
- R1: A synchronous reset makes the core halted (`running`=0) and clears AC, MBR, MAR, PC, IR and LR to zero.
- R2: An instruction word has its opcode in bits 17:16 and its address in bits 15:0. The opcode values are 00 store, 01 add, 10 jump-if-negative and 11 operate. Each instruction takes exactly 4 clocks with `running` high. The fetch does not change AC.
- R3: Add forms the one's complement sum of AC and the addressed word with end-around carry; for example, 0x3FFFE + 0x00003 gives 0x00002.
- R4: An add result of all ones (negative zero, 0x3FFFF) is kept as is.
- R5: Store writes AC to the addressed word during execute and leaves AC unchanged.
- R6: Jump-if-negative loads PC with the address when AC bit 17 is 1.
- R7: Jump-if-negative with AC bit 17 at 0 leaves PC at its incremented value.
- R8: Operate bits act in ascending step order:
  - bit0 clears AC;
  - bit1 copies AC to LR;
  - bit2 copies LR to AC;
  - bit3 complements AC;
  - bit4 ORs MBR (the operate word itself) into AC.
- R9: Operate bits 15:6 have no effect on AC, LR or PC.
- R10: Operate bit5 halts the core after the instruction. The core stays halted while run remains high, and it resumes from PC after run goes low and then high.
- R11: PC wraps modulo 2^16, so a fetch from 0xFFFF leaves PC at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Run request level |
| mem_rdata | input | 18 | Memory read data, valid one clock after the address |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 18 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| running | output | 1 | High while the core is not halted |
| ac | output | 18 | Accumulator |
| mbr | output | 18 | Memory buffer register |
| mar | output | 16 | Memory address register |
| pc | output | 16 | Program counter |
| ir | output | 2 | Instruction register (opcode) |
| lr | output | 18 | Live scratch register |

## Verification
Within one operate instruction, several transfers fire in the same clock. Examples are a copy AC to LR together with a complement of AC, a clear together with an OR from MBR, or any transfer together with the halt bit. Programs combine these bits in single operate words. Each final AC and LR is compared with a value worked out by applying the enabled steps strictly in ascending order. An order-independent or parallel implementation gives a different result. The halt-plus-transfer case is also judged on whether the core stops at the right PC with the transfer still applied.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int WORD_W   = 18;
    localparam int OP_W     = 2;
    localparam int ADDR_W   = WORD_W - OP_W;
    localparam int NUM_UOPS = 6;

    // micro-operation bit positions inside the operate word
    localparam int UOP_CLR  = 0;
    localparam int UOP_A2L  = 1;
    localparam int UOP_L2A  = 2;
    localparam int UOP_CMA  = 3;
    localparam int UOP_ORM  = 4;
    localparam int UOP_HALT = 5;

    typedef enum logic [OP_W-1:0] {
        OP_STO = 2'b00,
        OP_ADD = 2'b01,
        OP_TRN = 2'b10,
        OP_OPR = 2'b11
    } opcode_e;

    typedef enum logic [2:0] {
        S_HALT = 3'd0,
        S_FADR = 3'd1,
        S_FDAT = 3'd2,
        S_XADR = 3'd3,
        S_XDAT = 3'd4
    } mstate_e;

    // one's complement sum with end-around carry; the second add cannot overflow
    function automatic logic [WORD_W-1:0] oc_add(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
        logic [WORD_W:0] raw;
        raw = {1'b0, a} + {1'b0, b};
        return raw[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, raw[WORD_W]};
    endfunction

endpackage

// File: rtl/acc_uop_chain.sv
module acc_uop_chain
    import acc_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = NUM_UOPS
) (
    input  logic [W-1:0] ac_in,
    input  logic [W-1:0] lr_in,
    input  logic [W-1:0] mbr_in,
    input  logic [N-1:0] en,
    output logic [W-1:0] ac_out,
    output logic [W-1:0] lr_out
);

    logic [W-1:0] ac_s [N+1];
    logic [W-1:0] lr_s [N+1];

    assign ac_s[0] = ac_in;
    assign lr_s[0] = lr_in;

    // one stage per time step, applied in ascending bit order
    for (genvar g = 0; g < N; g++) begin : g_step
        if (g == UOP_CLR) begin : g_clr
            assign ac_s[g+1] = en[g] ? '0 : ac_s[g];
            assign lr_s[g+1] = lr_s[g];
        end else if (g == UOP_A2L) begin : g_a2l
            assign ac_s[g+1] = ac_s[g];
            assign lr_s[g+1] = en[g] ? ac_s[g] : lr_s[g];
        end else if (g == UOP_L2A) begin : g_l2a
            assign ac_s[g+1] = en[g] ? lr_s[g] : ac_s[g];
            assign lr_s[g+1] = lr_s[g];
        end else if (g == UOP_CMA) begin : g_cma
            assign ac_s[g+1] = en[g] ? ~ac_s[g] : ac_s[g];
            assign lr_s[g+1] = lr_s[g];
        end else if (g == UOP_ORM) begin : g_orm
            assign ac_s[g+1] = en[g] ? (ac_s[g] | mbr_in) : ac_s[g];
            assign lr_s[g+1] = lr_s[g];
        end else begin : g_pass
            assign ac_s[g+1] = ac_s[g];
            assign lr_s[g+1] = lr_s[g];
        end
    end

    assign ac_out = ac_s[N];
    assign lr_out = lr_s[N];

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  opcode_e ir,
    input  logic    halt_bit,
    output mstate_e state,
    output logic    running
);

    mstate_e state_d;
    logic    halt_pend;
    logic    halt_now;

    assign halt_now = (state == S_XDAT) && (ir == OP_OPR) && halt_bit;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_HALT;
            halt_pend <= 1'b0;
        end else begin
            state <= state_d;
            if (halt_now)
                halt_pend <= 1'b1;
            else if (!run)
                halt_pend <= 1'b0;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            S_HALT:  if (run && !halt_pend) state_d = S_FADR;
            S_FADR:  state_d = S_FDAT;
            S_FDAT:  state_d = S_XADR;
            S_XADR:  state_d = S_XDAT;
            S_XDAT:  state_d = (halt_now || !run) ? S_HALT : S_FADR;
            default: state_d = S_HALT;
        endcase
    end

    // outputs
    always_comb begin
        running = (state != S_HALT);
    end

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_FADR) |=> (state == S_FDAT));

    // R2
    stop_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> ($past(state) == S_XDAT));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_now && run) |=> (state == S_HALT));

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = ADDR_W,
    parameter int N  = NUM_UOPS
) (
    input  logic          clk,
    input  logic          rst,
    input  mstate_e       state,
    input  logic [W-1:0]  mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    output logic          mem_we,
    output logic [W-1:0]  ac,
    output logic [W-1:0]  mbr,
    output logic [AW-1:0] mar,
    output logic [AW-1:0] pc,
    output opcode_e       ir,
    output logic [W-1:0]  lr
);

    logic [W-1:0] chain_ac;
    logic [W-1:0] chain_lr;

    acc_uop_chain #(.W(W), .N(N)) u_chain (
        .ac_in  (ac),
        .lr_in  (lr),
        .mbr_in (mbr),
        .en     (mbr[N-1:0]),
        .ac_out (chain_ac),
        .lr_out (chain_lr)
    );

    always_comb begin
        mem_addr  = (state == S_FADR) ? pc : mar;
        mem_we    = (state == S_XADR) && (ir == OP_STO);
        mem_wdata = ac;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ac  <= '0;
            mbr <= '0;
            mar <= '0;
            pc  <= '0;
            ir  <= OP_STO;
            lr  <= '0;
        end else begin
            unique case (state)
                S_FDAT: begin
                    mbr <= mem_rdata;
                    ir  <= opcode_e'(mem_rdata[W-1:AW]);
                    mar <= mem_rdata[AW-1:0];
                    pc  <= pc + 1'b1;
                end
                S_XDAT: begin
                    unique case (ir)
                        OP_ADD: begin
                            mbr <= mem_rdata;
                            ac  <= oc_add(ac, mem_rdata);
                        end
                        OP_TRN: if (ac[W-1]) pc <= mar;
                        OP_OPR: begin
                            ac <= chain_ac;
                            lr <= chain_lr;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R5
    sto_keep_ac_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> $stable(ac));

    // R2
    fetch_keep_ac_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_FDAT) |=> $stable(ac));

    // R7
    trn_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_XDAT && ir == OP_TRN && !ac[W-1]) |=> $stable(pc));

    // R11
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_FDAT) |=> (pc == AW'($past(pc) + 1'b1)));

endmodule

// File: rtl/acc18_core.sv
module acc18_core
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              running,
    output logic [WORD_W-1:0] ac,
    output logic [WORD_W-1:0] mbr,
    output logic [ADDR_W-1:0] mar,
    output logic [ADDR_W-1:0] pc,
    output logic [OP_W-1:0]   ir,
    output logic [WORD_W-1:0] lr
);

    mstate_e state;
    opcode_e ir_e;

    acc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .ir       (ir_e),
        .halt_bit (mbr[UOP_HALT]),
        .state    (state),
        .running  (running)
    );

    acc_datapath #(.W(WORD_W), .AW(ADDR_W), .N(NUM_UOPS)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .ac        (ac),
        .mbr       (mbr),
        .mar       (mar),
        .pc        (pc),
        .ir        (ir_e),
        .lr        (lr)
    );

    assign ir = ir_e;

endmodule

// File: tb/acc18_core_tb.sv
`timescale 1ns/1ps
module acc18_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [17:0] mem_rdata;
    logic [15:0] mem_addr;
    logic [17:0] mem_wdata;
    logic        mem_we;
    logic        running;
    logic [17:0] ac, mbr, lr;
    logic [15:0] mar, pc;
    logic [1:0]  ir;

    logic [17:0] mem [256];
    logic        ld_we = 1'b0;
    logic [7:0]  ld_a  = '0;
    logic [17:0] ld_d  = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    acc18_core u_dut (
        .clk(clk), .rst(rst), .run(run), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .running(running), .ac(ac), .mbr(mbr), .mar(mar), .pc(pc),
        .ir(ir), .lr(lr)
    );

    // word memory, registered read, 8-bit decode
    always @(posedge clk) begin
        if (ld_we)       mem[ld_a] <= ld_d;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    function automatic logic [17:0] ins(input logic [1:0] op, input logic [15:0] a);
        return {op, a};
    endfunction

    localparam logic [1:0] STO = 2'b00, ADD = 2'b01, TRN = 2'b10, OPR = 2'b11;
    localparam logic [17:0] HALTW = 18'h30020;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] a, input logic [17:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_a = a; ld_d = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        rst = 1'b1; run = 1'b0;
        for (int i = 0; i < 256; i++) load(i[7:0], 18'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // run until halt; returns clocks spent with running high
    task automatic run_prog(input bit keep, output int cyc);
        cyc = 0;
        @(negedge clk);
        run = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (running) cyc++;
            else if (cyc > 0) break;
        end
        if (running) begin
            errors++;
            $display("FAIL run_prog: program did not halt");
        end
        if (!keep) run = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 running", running, 0);
        check("R1 ac", ac, 0);
        check("R1 pc", pc, 0);
        check("R1 lr", lr, 0);
        check("R1 mbr", mbr, 0);
        check("R1 mar", mar, 0);
        check("R1 ir", ir, 0);
    endtask

    task automatic t_add();
        int c;
        restart();
        load(0, ins(ADD, 16)); load(1, ins(ADD, 17)); load(2, HALTW);
        load(16, 18'd5); load(17, 18'd7);
        run_prog(0, c);
        check("R2 clocks for 3 instructions", c, 12);
        check("R3 add sum", ac, 12);
        check("R2 pc", pc, 3);
    endtask

    task automatic t_carry();
        int c;
        restart();
        load(0, ins(ADD, 16)); load(1, ins(ADD, 17)); load(2, HALTW);
        load(16, 18'h3FFFE); load(17, 18'h00003);
        run_prog(0, c);
        check("R3 end-around carry", ac, 18'h00002);
    endtask

    task automatic t_negzero();
        int c;
        restart();
        load(0, ins(ADD, 16)); load(1, ins(ADD, 17)); load(2, HALTW);
        load(16, 18'h00005); load(17, 18'h3FFFA);
        run_prog(0, c);
        check("R4 negative zero kept", ac, 18'h3FFFF);
    endtask

    task automatic t_store();
        int c;
        restart();
        load(0, ins(ADD, 16)); load(1, ins(STO, 20)); load(2, HALTW);
        load(16, 18'h01234);
        run_prog(0, c);
        check("R5 stored word", mem[20], 18'h01234);
        check("R5 ac unchanged", ac, 18'h01234);
    endtask

    task automatic t_trn();
        int c;
        restart();
        load(0, ins(ADD, 16)); load(1, ins(TRN, 5)); load(2, HALTW); load(5, HALTW);
        load(16, 18'h20000);
        run_prog(0, c);
        check("R6 jump taken pc", pc, 6);
        restart();
        load(0, ins(ADD, 16)); load(1, ins(TRN, 5)); load(2, HALTW); load(5, HALTW);
        load(16, 18'h00001);
        run_prog(0, c);
        check("R7 jump not taken pc", pc, 3);
        check("R7 clocks", c, 12);
    endtask

    task automatic t_opr();
        int c;
        // copy then complement
        restart();
        load(0, ins(ADD, 16)); load(1, 18'h3000A); load(2, HALTW);
        load(16, 18'h000F0);
        run_prog(0, c);
        check("R8 a2l before complement lr", lr, 18'h000F0);
        check("R8 complement ac", ac, 18'h3FF0F);
        // clear then OR operate word
        restart();
        load(0, ins(ADD, 16)); load(1, 18'h30011); load(2, HALTW);
        load(16, 18'h00155);
        run_prog(0, c);
        check("R8 clear then or mbr", ac, 18'h30011);
        // lr to ac then complement
        restart();
        load(0, ins(ADD, 16)); load(1, 18'h30002); load(2, 18'h30001);
        load(3, 18'h3000C); load(4, HALTW);
        load(16, 18'h000AA);
        run_prog(0, c);
        check("R8 l2a then complement ac", ac, 18'h3FF55);
        check("R8 lr kept", lr, 18'h000AA);
        // unused bits
        restart();
        load(0, ins(ADD, 16)); load(1, 18'h3FFC0); load(2, HALTW);
        load(16, 18'h00777);
        run_prog(0, c);
        check("R9 unused bits ac", ac, 18'h00777);
        check("R9 unused bits lr", lr, 0);
        check("R9 unused bits pc", pc, 3);
    endtask

    task automatic t_halt();
        int c;
        int seen;
        // halt together with a transfer
        restart();
        load(0, ins(ADD, 16)); load(1, 18'h30022); load(2, ins(ADD, 16)); load(3, HALTW);
        load(16, 18'h00009);
        run_prog(1, c);
        check("R10 halt pc", pc, 2);
        check("R8 transfer in halt word", lr, 18'h00009);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (running) seen++;
        end
        check("R10 stays halted with run high", seen, 0);
        check("R10 pc held", pc, 2);
        @(negedge clk); run = 1'b0;
        @(negedge clk); @(negedge clk);
        run_prog(0, c);
        check("R10 resumed ac", ac, 18'h00012);
        check("R10 resumed pc", pc, 4);
    endtask

    task automatic t_wrap();
        int c;
        restart();
        load(0, ins(ADD, 16)); load(1, ins(TRN, 16'hFFFF)); load(8'hFF, HALTW);
        load(16, 18'h20000);
        run_prog(0, c);
        check("R11 pc wraps", pc, 16'h0000);
        check("R11 clocks", c, 12);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_add();
        t_carry();
        t_negzero();
        t_store();
        t_trn();
        t_opr();
        t_halt();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule